// File: doc/BRIEF.md
# Three-Wire Serial Port for a Segment LCD Display Memory

This block is the host-facing side of a segment LCD controller. A host talks to it over three wires: an active-low chip select, separate write and read strobes, and a single data line. The block parses the bit stream into transactions. Each transaction starts with a short mode identifier. Command transactions deliver 9-bit control words to the rest of the controller. Data transactions load an address pointer and then move whole 8-bit words into or out of a 48-column by 8-bit display memory.

The pointer advances on its own after each completed word, so a host can stream consecutive columns after sending one start address. The display memory is held inside the block. The LCD scan logic reads it through a separate combinational read port. All three host pins are brought into the core clock domain through a synchronizer before edges are detected. The bidirectional data line is split into an input, an output and an output-enable.

Top module: `lcd_ser_if`

## Requirements
- R1: While rst_ni is low, data_oe_o and cmd_valid_o are 0, and every display column reads back as 0.
- R2: Mode identifier 101 (three bits, MSB first, each captured on a rising edge of wr_i) selects write mode. It is followed by a 6-bit address, MSB first. Each following group of 8 wr_i bits forms a word, LSB first, which is stored at the pointer. The pointer then advances by one.
- R3: Identifier 110 selects read mode. It is followed by a 6-bit address. Each rising edge of rd_i puts the next bit of the word at the pointer on data_o, LSB first. After the 8th bit the pointer advances.
- R4: The pointer wraps from column 47 to column 0, in both write and read modes.
- R5: In write mode, rd_i edges read out the word at the pointer, LSB first, without moving it. A following 8-bit write then replaces that same word and advances the pointer (read-modify-write).
- R6: Identifier 100 selects command mode. Every 9 following wr_i bits, MSB first, appear on cmd_o with a one-cycle cmd_valid_o pulse. Any number of commands may follow within one chip-select window.
- R7: Raising cs_n_i abandons any partial transaction. No partial word is written. The next low window starts again with a mode identifier.
- R8: data_oe_o is 1 only after a read edge inside a data transaction while cs_n_i is low. It drops on a write bit in write mode, and whenever cs_n_i goes high.
- R9: Any other identifier makes the rest of the window be ignored: no write and no command.
- R10: A start address of 48 to 63 loads the pointer with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| wr_i | input | 1 | Write strobe, data captured on rising edge |
| rd_i | input | 1 | Read strobe, next bit launched on rising edge |
| data_i | input | 1 | Serial data from host |
| data_o | output | 1 | Serial data to host |
| data_oe_o | output | 1 | Drive enable for the data line |
| cmd_valid_o | output | 1 | One-cycle strobe for a complete command word |
| cmd_o | output | 9 | Last complete command word |
| disp_addr_i | input | 6 | Display column read address |
| disp_data_o | output | 8 | Display column contents |

## Verification
A pin change takes two synchronizer cycles plus one edge-detect register before it is seen. So data_o, data_oe_o and cmd_valid_o respond on the third rising clock edge after a strobe edge. A finished word lands in the display memory one edge after that. The bench holds each strobe level for four clock cycles and samples only at falling clock edges, after those four cycles. Command words go into an expectation queue; a monitor pops one for every cmd_valid_o pulse it sees, and any extra pulse or word left in the queue counts as a miscompare.

// File: rtl/lcd_ser_pkg.sv
package lcd_ser_pkg;
  localparam int unsigned DEF_COLS   = 48;
  localparam int unsigned DEF_WORD_W = 8;
  localparam int unsigned DEF_CMD_W  = 9;
  localparam int unsigned ID_W       = 3;

  localparam logic [ID_W-1:0] ID_WRITE = 3'b101;
  localparam logic [ID_W-1:0] ID_READ  = 3'b110;
  localparam logic [ID_W-1:0] ID_CMD   = 3'b100;

  typedef enum logic [2:0] {
    ST_ID,
    ST_ADDR,
    ST_DATA,
    ST_CMD,
    ST_SKIP
  } ser_st_e;
endpackage

// File: rtl/lcd_ser_sync.sv
module lcd_ser_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(STAGES); s++) stg_q[s] <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
  parameter int unsigned COLS   = 48,
  parameter int unsigned WORD_W = 8,
  localparam int unsigned ADDR_W = $clog2(COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [WORD_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [WORD_W-1:0] rdata_b_o
);
  logic [WORD_W-1:0] mem_q [COLS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < int'(COLS); c++) mem_q[c] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = (32'(raddr_a_i) < COLS) ? mem_q[raddr_a_i] : '0;
  assign rdata_b_o = (32'(raddr_b_i) < COLS) ? mem_q[raddr_b_i] : '0;
endmodule

// File: rtl/lcd_ser_ctrl.sv
module lcd_ser_ctrl
  import lcd_ser_pkg::*;
#(
  parameter int unsigned COLS   = 48,
  parameter int unsigned WORD_W = 8,
  parameter int unsigned CMD_W  = 9,
  localparam int unsigned ADDR_W = $clog2(COLS),
  localparam int unsigned BIT_W  = $clog2(WORD_W),
  localparam int unsigned SH_W   = (CMD_W > ADDR_W) ? CMD_W : ADDR_W,
  localparam int unsigned CNT_W  = $clog2(SH_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              din_i,
  input  logic [WORD_W-1:0] ram_rdata_i,
  output logic [ADDR_W-1:0] ram_ptr_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_waddr_o,
  output logic [WORD_W-1:0] ram_wdata_o,
  output logic              cmd_valid_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              dout_o,
  output logic              doe_o
);
  ser_st_e           state_q;
  logic              is_read_q;
  logic              wr_q, rd_q;
  logic [SH_W-1:0]   shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [WORD_W-1:0] wbuf_q;
  logic [BIT_W-1:0]  widx_q, ridx_q;
  logic              dout_q, doe_q, we_q, cmd_v_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [CMD_W-1:0]  cmd_q;

  logic              wr_rise, rd_rise;
  logic [SH_W-1:0]   shift_nx;
  logic [ADDR_W-1:0] ptr_nx;
  logic [WORD_W-1:0] word_nx;

  assign wr_rise  = wr_i & ~wr_q;
  assign rd_rise  = rd_i & ~rd_q;
  assign shift_nx = {shift_q[SH_W-2:0], din_i};
  assign ptr_nx   = (ptr_q == ADDR_W'(COLS - 1)) ? '0 : ptr_q + 1'b1;

  always_comb begin
    word_nx         = wbuf_q;
    word_nx[widx_q] = din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      wr_q <= wr_i;
      rd_q <= rd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_ID;
      is_read_q <= 1'b0;
      shift_q   <= '0;
      cnt_q     <= '0;
      ptr_q     <= '0;
      wbuf_q    <= '0;
      widx_q    <= '0;
      ridx_q    <= '0;
      dout_q    <= 1'b0;
      doe_q     <= 1'b0;
      we_q      <= 1'b0;
      waddr_q   <= '0;
      wdata_q   <= '0;
      cmd_v_q   <= 1'b0;
      cmd_q     <= '0;
    end else begin
      we_q    <= 1'b0;
      cmd_v_q <= 1'b0;
      if (cs_n_i) begin
        state_q <= ST_ID;
        cnt_q   <= '0;
        doe_q   <= 1'b0;
        widx_q  <= '0;
        ridx_q  <= '0;
      end else begin
        unique case (state_q)
          ST_ID: if (wr_rise) begin
            shift_q <= shift_nx;
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(ID_W - 1)) begin
              cnt_q <= '0;
              unique case (shift_nx[ID_W-1:0])
                ID_WRITE: begin state_q <= ST_ADDR; is_read_q <= 1'b0; end
                ID_READ:  begin state_q <= ST_ADDR; is_read_q <= 1'b1; end
                ID_CMD:   state_q <= ST_CMD;
                default:  state_q <= ST_SKIP;
              endcase
            end
          end
          ST_ADDR: if (wr_rise) begin
            shift_q <= shift_nx;
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(ADDR_W - 1)) begin
              cnt_q   <= '0;
              // out-of-range start address falls back to column 0
              ptr_q   <= (32'(shift_nx[ADDR_W-1:0]) < COLS) ? shift_nx[ADDR_W-1:0] : '0;
              widx_q  <= '0;
              ridx_q  <= '0;
              state_q <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (rd_rise) begin
              dout_q <= ram_rdata_i[ridx_q];
              doe_q  <= 1'b1;
              if (ridx_q == BIT_W'(WORD_W - 1)) begin
                ridx_q <= '0;
                if (is_read_q) ptr_q <= ptr_nx;
              end else begin
                ridx_q <= ridx_q + 1'b1;
              end
            end else if (wr_rise && !is_read_q) begin
              doe_q  <= 1'b0;
              wbuf_q <= word_nx;
              if (widx_q == BIT_W'(WORD_W - 1)) begin
                we_q    <= 1'b1;
                waddr_q <= ptr_q;
                wdata_q <= word_nx;
                ptr_q   <= ptr_nx;
                widx_q  <= '0;
                ridx_q  <= '0;
              end else begin
                widx_q <= widx_q + 1'b1;
              end
            end
          end
          ST_CMD: if (wr_rise) begin
            shift_q <= shift_nx;
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(CMD_W - 1)) begin
              cnt_q   <= '0;
              cmd_q   <= shift_nx[CMD_W-1:0];
              cmd_v_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ram_ptr_o   = ptr_q;
  assign ram_we_o    = we_q;
  assign ram_waddr_o = waddr_q;
  assign ram_wdata_o = wdata_q;
  assign cmd_valid_o = cmd_v_q;
  assign cmd_o       = cmd_q;
  assign dout_o      = dout_q;
  assign doe_o       = doe_q;
endmodule

// File: rtl/lcd_ser_if.sv
module lcd_ser_if
  import lcd_ser_pkg::*;
#(
  parameter int unsigned COLS        = DEF_COLS,
  parameter int unsigned WORD_W      = DEF_WORD_W,
  parameter int unsigned CMD_W       = DEF_CMD_W,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W     = $clog2(COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              data_i,
  output logic              data_o,
  output logic              data_oe_o,
  output logic              cmd_valid_o,
  output logic [CMD_W-1:0]  cmd_o,
  input  logic [ADDR_W-1:0] disp_addr_i,
  output logic [WORD_W-1:0] disp_data_o
);
  logic [3:0]        pins_s;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr, ram_ptr;
  logic [WORD_W-1:0] ram_wdata, ram_rdata;

  lcd_ser_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_n_i, wr_i, rd_i, data_i}),
    .q_o    (pins_s)
  );

  lcd_ser_ctrl #(.COLS(COLS), .WORD_W(WORD_W), .CMD_W(CMD_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_n_i      (pins_s[3]),
    .wr_i        (pins_s[2]),
    .rd_i        (pins_s[1]),
    .din_i       (pins_s[0]),
    .ram_rdata_i (ram_rdata),
    .ram_ptr_o   (ram_ptr),
    .ram_we_o    (ram_we),
    .ram_waddr_o (ram_waddr),
    .ram_wdata_o (ram_wdata),
    .cmd_valid_o (cmd_valid_o),
    .cmd_o       (cmd_o),
    .dout_o      (data_o),
    .doe_o       (data_oe_o)
  );

  lcd_disp_ram #(.COLS(COLS), .WORD_W(WORD_W)) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ram_we),
    .waddr_i   (ram_waddr),
    .wdata_i   (ram_wdata),
    .raddr_a_i (ram_ptr),
    .rdata_a_o (ram_rdata),
    .raddr_b_i (disp_addr_i),
    .rdata_b_o (disp_data_o)
  );
endmodule

// File: rtl/lcd_ser_if_chk.sv
module lcd_ser_if_chk #(
  parameter int unsigned COLS = 48,
  localparam int unsigned ADDR_W = $clog2(COLS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_n_i,
  input logic              data_oe_o,
  input logic              cmd_valid_o,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_waddr,
  input logic [ADDR_W-1:0] ram_ptr
);
  p_oe_released_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !data_oe_o);

  p_cmd_no_drive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !data_oe_o);

  p_cmd_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  p_we_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |=> !ram_we);

  p_waddr_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |-> (32'(ram_waddr) < COLS));

  p_ptr_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ram_ptr) < COLS);
endmodule

bind lcd_ser_if lcd_ser_if_chk #(.COLS(COLS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_n_i      (cs_n_i),
  .data_oe_o   (data_oe_o),
  .cmd_valid_o (cmd_valid_o),
  .ram_we      (ram_we),
  .ram_waddr   (ram_waddr),
  .ram_ptr     (ram_ptr)
);

// File: tb/lcd_ser_if_tb.sv
module lcd_ser_if_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_n_i = 1'b1, wr_i = 1'b1, rd_i = 1'b1, data_i = 1'b1;
  logic       data_o, data_oe_o, cmd_valid_o;
  logic [8:0] cmd_o;
  logic [5:0] disp_addr_i = '0;
  logic [7:0] disp_data_o;

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;
  logic [8:0] exp_cmd [$];

  always #4 clk_i = ~clk_i;

  lcd_ser_if u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_n_i(cs_n_i), .wr_i(wr_i), .rd_i(rd_i),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
    .cmd_valid_o(cmd_valid_o), .cmd_o(cmd_o),
    .disp_addr_i(disp_addr_i), .disp_data_o(disp_data_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  // scoreboard monitor for command words (R6, R9)
  always @(negedge clk_i) begin
    if (rst_ni && cmd_valid_o) begin
      if (exp_cmd.size() == 0) begin
        check("R6/R9 unexpected command", {23'd0, cmd_o}, 32'hFFFF_FFFF);
      end else begin
        logic [8:0] e;
        e = exp_cmd.pop_front();
        check("R6 command word", {23'd0, cmd_o}, {23'd0, e});
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_bit(input logic b);
    data_i = b; wr_i = 1'b0; wait_n(4);
    wr_i = 1'b1; wait_n(4);
  endtask

  task automatic send_msb(input logic [8:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) wr_bit(v[i]);
  endtask

  task automatic send_word(input logic [7:0] w);
    for (int i = 0; i < 8; i++) wr_bit(w[i]);
  endtask

  task automatic read_word(output logic [7:0] w, output logic oe_all);
    oe_all = 1'b1;
    for (int i = 0; i < 8; i++) begin
      rd_i = 1'b0; wait_n(4);
      rd_i = 1'b1; wait_n(4);
      w[i] = data_o;
      oe_all &= data_oe_o;
    end
  endtask

  task automatic cs_on();
    cs_n_i = 1'b0; wait_n(4);
  endtask

  task automatic cs_off();
    cs_n_i = 1'b1; data_i = 1'b1; wait_n(6);
  endtask

  task automatic peek(input logic [5:0] a, output logic [7:0] d);
    disp_addr_i = a; wait_n(1); d = disp_data_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] w;
    logic oe;
    wait_n(3);
    // R1 reset state
    check("R1 oe in reset", {31'd0, data_oe_o}, 0);
    check("R1 cmd_valid in reset", {31'd0, cmd_valid_o}, 0);
    peek(6'd20, w); check("R1 display cleared", {24'd0, w}, 0);
    rst_ni = 1'b1; wait_n(3);

    // R2 write stream with auto increment
    cs_on(); send_msb(9'b101, 3); send_msb(9'd5, 6);
    send_word(8'hA5); send_word(8'h3C); send_word(8'h7E);
    check("R8 oe low while writing", {31'd0, data_oe_o}, 0);
    cs_off();
    peek(6'd5, w); check("R2 col5", {24'd0, w}, 32'hA5);
    peek(6'd6, w); check("R2 col6", {24'd0, w}, 32'h3C);
    peek(6'd7, w); check("R2 col7", {24'd0, w}, 32'h7E);

    // R3 read stream
    cs_on(); send_msb(9'b110, 3); send_msb(9'd5, 6);
    check("R8 oe low before read edge", {31'd0, data_oe_o}, 0);
    read_word(w, oe); check("R3 read col5", {24'd0, w}, 32'hA5);
    check("R8 oe high during read", {31'd0, oe}, 1);
    read_word(w, oe); check("R3 read col6 auto increment", {24'd0, w}, 32'h3C);
    cs_off();
    check("R8 oe released after cs high", {31'd0, data_oe_o}, 0);

    // R4 wrap 47 -> 0
    cs_on(); send_msb(9'b101, 3); send_msb(9'd47, 6);
    send_word(8'h11); send_word(8'h22); cs_off();
    peek(6'd47, w); check("R4 write col47", {24'd0, w}, 32'h11);
    peek(6'd0, w);  check("R4 write wrapped col0", {24'd0, w}, 32'h22);
    cs_on(); send_msb(9'b110, 3); send_msb(9'd47, 6);
    read_word(w, oe); check("R4 read col47", {24'd0, w}, 32'h11);
    read_word(w, oe); check("R4 read wrapped col0", {24'd0, w}, 32'h22);
    cs_off();

    // R5 read-modify-write
    cs_on(); send_msb(9'b101, 3); send_msb(9'd6, 6);
    read_word(w, oe); check("R5 rmw read col6", {24'd0, w}, 32'h3C);
    send_word(8'hC3);
    check("R8 oe dropped by write bit", {31'd0, data_oe_o}, 0);
    send_word(8'h99); cs_off();
    peek(6'd6, w); check("R5 rmw col6 replaced", {24'd0, w}, 32'hC3);
    peek(6'd7, w); check("R5 rmw next col7", {24'd0, w}, 32'h99);
    peek(6'd8, w); check("R5 col8 untouched", {24'd0, w}, 0);

    // R6 back-to-back commands
    cs_on(); send_msb(9'b100, 3);
    exp_cmd.push_back(9'h1A5); send_msb(9'h1A5, 9);
    exp_cmd.push_back(9'h003); send_msb(9'h003, 9);
    cs_off();
    check("R6 all commands seen", exp_cmd.size(), 0);

    // R7 abort partial word, then restart
    cs_on(); send_msb(9'b101, 3); send_msb(9'd10, 6);
    wr_bit(1'b1); wr_bit(1'b1); wr_bit(1'b1); wr_bit(1'b1); cs_off();
    peek(6'd10, w); check("R7 partial word discarded", {24'd0, w}, 0);
    cs_on(); wr_bit(1'b1); wr_bit(1'b0); cs_off();
    cs_on(); send_msb(9'b101, 3); send_msb(9'd10, 6); send_word(8'h5A); cs_off();
    peek(6'd10, w); check("R7 restart after abort", {24'd0, w}, 32'h5A);

    // R9 unknown identifier ignored
    cs_on(); send_msb(9'b111, 3); send_msb(9'b000_000_100, 9);
    send_word(8'hFF); cs_off();
    peek(6'd0, w); check("R9 col0 unchanged", {24'd0, w}, 32'h22);
    peek(6'd4, w); check("R9 col4 unchanged", {24'd0, w}, 0);
    check("R9 no command issued", exp_cmd.size(), 0);

    // R10 out-of-range start address
    cs_on(); send_msb(9'b101, 3); send_msb(9'd50, 6); send_word(8'h77); cs_off();
    peek(6'd0, w); check("R10 addr 50 maps to col0", {24'd0, w}, 32'h77);

    wait_n(4);
    report();
  end
endmodule